// File: doc/BRIEF.md
# Byte-Wide Code Array Programming Port

This block is the device side of a parallel programming port for an on-chip code store of 2048 bytes. An external programmer never presents an address. Instead, an address counter inside the block is cleared by a rising edge on a clear pin and moved forward by one on each rising edge of a step pin. The programmer picks an operation with four mode pins. It places a byte on the data input and fires a strobe while the high-voltage enable is held. Byte writes, lock-bit writes and whole-array erase each start a self-timed busy window whose length is a parameter in clock cycles.

Read-back is on the same data path. In code-read mode the output shows the byte under the counter. If that byte is the one whose write is still running, bit 7 shows the inverse of the bit that was written, so the programmer can poll for completion. Two sticky lock bits restrict writes and read-back, and a signature mode returns fixed identification bytes. The non-volatile store is modelled as a register array that comes out of reset erased. All pins are taken to be synchronous to `clk`.

Top module: `flash_prog_port`

## Requirements
- R1: After `rst_n` is released, `busy` is 0, the address counter is 000H, both lock bits are clear and every location reads FFH.
- R2: A rising edge on `cnt_clr` sets the address counter to 000H. This wins over a `cnt_step` edge in the same cycle.
- R3: Each rising edge of `cnt_step` adds one to the address counter, and 7FFH is followed by 000H.
- R4: With mode 4'b1110, `hv_en` high, LB1 clear and `busy` low, a rising edge of `prog_strobe` writes `din` into the addressed byte. `busy` is then high for exactly WRITE_CYCLES clock cycles.
- R5: A byte write can only clear bits: the stored byte becomes the old byte AND `din`.
- R6: In code-read mode, while a byte write is busy and the counter points at the byte being written, `dout[7]` is the inverse of the written bit 7. Once `busy` falls, the full true byte is returned.
- R7: `cnt_step` edges and `prog_strobe` edges that arrive while `busy` is high are ignored.
- R8: Mode 4'b1111 sets lock bit LB1 and mode 4'b1011 sets lock bit LB2, each with `hv_en` and a strobe edge. While LB1 is set, byte writes change nothing. While both are set, code reads return FFH.
- R9: Mode 4'b1000 with `hv_en` and a strobe edge sets every byte to FFH and clears both lock bits.
- R10: In mode 4'b0000, addresses 000H, 001H and 002H return 1EH, 21H and the SIG_BYTE2 parameter (default 23H), and any other address returns FFH, whatever the lock bits are.
- R11: Mode 4'b0011 returns the addressed byte on `dout` one clock after the mode and address are presented. Any mode pattern not listed returns FFH, and a strobe in such a mode, or a strobe with `hv_en` low, starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_clr | input | 1 | Address counter clear, acts on its rising edge |
| cnt_step | input | 1 | Address counter advance, acts on its rising edge |
| hv_en | input | 1 | Programming voltage present, required for any write |
| prog_strobe | input | 1 | Operation strobe, acts on its rising edge |
| mode_sel | input | 4 | Operation select pattern |
| din | input | 8 | Data byte to program |
| dout | output | 8 | Registered read-back byte |
| busy | output | 1 | Self-timed operation in progress |

## Verification
The bench goes after the corners where a plausible design slips. A second write to the same byte must AND into it; a design that overwrites returns the new byte instead. A design that skips the polling inversion shows the true bit 7 while `busy` is high. If the step or strobe gating during busy is missing, the following read lands on the neighbouring byte or finds the byte cleared to 00H. The bench also checks that the counter wraps after 7FFH back to the first byte, that a simultaneous clear beats a step, that LB1 blocks writes and both locks blank code reads while signatures stay readable, and that erase lifts the locks. A design with a busy-length error or a wrong signature table gives a count or byte that differs from the expected value.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
   localparam logic [3:0] MODE_WR_CODE = 4'b1110;
   localparam logic [3:0] MODE_RD_CODE = 4'b0011;
   localparam logic [3:0] MODE_WR_LK1  = 4'b1111;
   localparam logic [3:0] MODE_WR_LK2  = 4'b1011;
   localparam logic [3:0] MODE_ERASE   = 4'b1000;
   localparam logic [3:0] MODE_RD_SIG  = 4'b0000;
   localparam logic [7:0] SIG_BYTE0    = 8'h1E;
   localparam logic [7:0] SIG_BYTE1    = 8'h21;
   localparam logic [7:0] BLANK_BYTE   = 8'hFF;
endpackage

// File: rtl/fpi_rise_det.sv
module fpi_rise_det #(
   parameter int unsigned WIDTH = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level_i,
   output logic [WIDTH-1:0] rise_o
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level_i;
   end

   assign rise_o = level_i & ~prev_q;

   initial assert (WIDTH >= 1) else $error("fpi_rise_det: WIDTH must be at least 1");
endmodule

// File: rtl/fpi_addr_ctr.sv
module fpi_addr_ctr #(
   parameter int unsigned DEPTH  = 2048,
   localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              step_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] addr_inc;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign addr_inc = addr_q + 1'b1;
      end else begin : g_mod
         assign addr_inc = (addr_q == LAST) ? '0 : addr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q <= '0;
      else if (clr_i)  addr_q <= '0;
      else if (step_i) addr_q <= addr_inc;
   end

   assign addr_o = addr_q;

   initial assert (DEPTH >= 4) else $error("fpi_addr_ctr: DEPTH must be at least 4");

   AST_CLR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> addr_q == '0); // R2
   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !clr_i) |=> addr_q == (($past(addr_q) == LAST) ? '0 : $past(addr_q) + 1'b1)); // R3
endmodule

// File: rtl/fpi_wr_timer.sv
module fpi_wr_timer #(
   parameter int unsigned WRITE_CYCLES = 24000,
   localparam int unsigned CW = $clog2(WRITE_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (start_i)      cnt_q <= CW'(WRITE_CYCLES);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);

   initial assert (WRITE_CYCLES >= 2) else $error("fpi_wr_timer: WRITE_CYCLES must be at least 2");

   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_o); // R7
   AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> busy_o); // R4
endmodule

// File: rtl/flash_prog_port.sv
module flash_prog_port
   import flash_prog_pkg::*;
#(
   parameter int unsigned DEPTH        = 2048,
   parameter int unsigned WRITE_CYCLES = 24000,
   parameter logic [7:0]  SIG_BYTE2    = 8'h23
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cnt_clr,
   input  logic       cnt_step,
   input  logic       hv_en,
   input  logic       prog_strobe,
   input  logic [3:0] mode_sel,
   input  logic [7:0] din,
   output logic [7:0] dout,
   output logic       busy
);
   localparam int unsigned ADDR_W = $clog2(DEPTH);

   logic [2:0]        rise;
   logic              clr_rise, step_rise, stb_rise;
   logic [ADDR_W-1:0] addr;
   logic              op_ok, do_code, do_lk1, do_lk2, do_erase, op_start;
   logic [7:0]        mem_q [DEPTH];
   logic              lk1_q, lk2_q;
   logic [ADDR_W-1:0] last_addr_q;
   logic              last_b7_q;
   logic [7:0]        rd_byte, dout_q;

   fpi_rise_det #(.WIDTH(3)) u_edges (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i ({prog_strobe, cnt_step, cnt_clr}),
      .rise_o  (rise)
   );
   assign clr_rise  = rise[0];
   assign step_rise = rise[1];
   assign stb_rise  = rise[2];

   fpi_addr_ctr #(.DEPTH(DEPTH)) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr_rise),
      .step_i (step_rise && !busy),
      .addr_o (addr)
   );

   assign op_ok    = stb_rise && hv_en && !busy;
   assign do_code  = op_ok && (mode_sel == MODE_WR_CODE) && !lk1_q;
   assign do_lk1   = op_ok && (mode_sel == MODE_WR_LK1);
   assign do_lk2   = op_ok && (mode_sel == MODE_WR_LK2);
   assign do_erase = op_ok && (mode_sel == MODE_ERASE);
   assign op_start = do_code || do_lk1 || do_lk2 || do_erase;

   fpi_wr_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (op_start),
      .busy_o  (busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= BLANK_BYTE;
         lk1_q       <= 1'b0;
         lk2_q       <= 1'b0;
         last_addr_q <= '0;
         last_b7_q   <= 1'b0;
      end else begin
         if (do_erase) begin
            for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= BLANK_BYTE;
            lk1_q <= 1'b0;
            lk2_q <= 1'b0;
         end
         if (do_code) begin
            mem_q[addr] <= mem_q[addr] & din;
            last_addr_q <= addr;
            last_b7_q   <= din[7];
         end
         if (do_lk1) lk1_q <= 1'b1;
         if (do_lk2) lk2_q <= 1'b1;
      end
   end

   always_comb begin
      rd_byte = BLANK_BYTE;
      case (mode_sel)
         MODE_RD_CODE: begin
            if (lk1_q && lk2_q)                     rd_byte = BLANK_BYTE;
            else if (busy && addr == last_addr_q)   rd_byte = {~last_b7_q, mem_q[addr][6:0]};
            else                                    rd_byte = mem_q[addr];
         end
         MODE_RD_SIG: begin
            if (addr == ADDR_W'(0))      rd_byte = SIG_BYTE0;
            else if (addr == ADDR_W'(1)) rd_byte = SIG_BYTE1;
            else if (addr == ADDR_W'(2)) rd_byte = SIG_BYTE2;
            else                         rd_byte = BLANK_BYTE;
         end
         default: rd_byte = BLANK_BYTE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout_q <= BLANK_BYTE;
      else        dout_q <= rd_byte;
   end

   assign dout = dout_q;

   initial assert (DEPTH >= 4 && DEPTH <= 4096) else $error("flash_prog_port: DEPTH out of range");

   AST_ONLY_CLEARS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      !do_erase |=> (mem_q[$past(addr)] & ~$past(mem_q[addr])) == 8'h00); // R5
   AST_LOCK1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (lk1_q && !do_erase) |=> lk1_q); // R8
   AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (lk1_q && !do_erase) |=> mem_q[$past(addr)] == $past(mem_q[addr])); // R8
   AST_LOCKED_READ_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      (lk1_q && lk2_q && mode_sel == MODE_RD_CODE) |=> dout == BLANK_BYTE); // R8
   AST_ERASE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      do_erase |=> (mem_q[0] == BLANK_BYTE && !lk1_q && !lk2_q)); // R9
   AST_STEP_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (step_rise && busy && !clr_rise) |=> $stable(addr)); // R7
endmodule

// File: tb/flash_prog_port_tb.sv
module flash_prog_port_tb_top;
   localparam int unsigned W   = 40;
   localparam logic [7:0]  SG2 = 8'h23;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cnt_clr = 1'b0, cnt_step = 1'b0, hv_en = 1'b0, prog_strobe = 1'b0;
   logic [3:0] mode_sel = 4'b0011;
   logic [7:0] din = 8'h00;
   logic [7:0] dout;
   logic       busy;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   flash_prog_port #(.DEPTH(2048), .WRITE_CYCLES(W), .SIG_BYTE2(SG2)) dut_i (
      .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .cnt_step(cnt_step),
      .hv_en(hv_en), .prog_strobe(prog_strobe), .mode_sel(mode_sel),
      .din(din), .dout(dout), .busy(busy)
   );

   // {step before write, data written, expected byte after}
   localparam logic [16:0] VEC [6] = '{
      {1'b0, 8'hA5, 8'hA5},
      {1'b0, 8'h3C, 8'h24},
      {1'b1, 8'h7E, 8'h7E},
      {1'b1, 8'h81, 8'h81},
      {1'b0, 8'hFF, 8'h81},
      {1'b1, 8'h00, 8'h00}
   };

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic pulse_step();
      cnt_step = 1'b1; @(negedge clk); cnt_step = 1'b0; @(negedge clk);
   endtask

   task automatic pulse_clr();
      cnt_clr = 1'b1; @(negedge clk); cnt_clr = 1'b0; @(negedge clk);
   endtask

   task automatic fire(logic [3:0] m, logic hv, logic [7:0] d);
      mode_sel = m; hv_en = hv; din = d;
      prog_strobe = 1'b1; @(negedge clk); prog_strobe = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      mode_sel = 4'b0011; hv_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic read(logic [3:0] m, output logic [7:0] v);
      mode_sel = m; @(negedge clk); v = dout;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 busy after reset", {7'd0, busy}, 8'h00);
      read(4'b0011, v); check("R1 blank byte at 000H", v, 8'hFF);

      // table walk: R4 R5 R6 R7
      for (int i = 0; i < 6; i++) begin
         if (VEC[i][16]) pulse_step();
         fire(4'b1110, 1'b1, VEC[i][15:8]);
         read(4'b0011, v);
         check("R6 polling bit 7", {7'd0, v[7]}, {7'd0, ~VEC[i][15]});
         pulse_step();                       // R7 ignored while busy
         fire(4'b1110, 1'b1, 8'h00);         // R7 ignored while busy
         mode_sel = 4'b0011;
         wait_idle();
         read(4'b0011, v); check("R5/R7 stored byte", v, VEC[i][7:0]);
      end

      // R3 wrap
      pulse_clr();
      for (int k = 0; k < 2047; k++) pulse_step();
      read(4'b0011, v); check("R3 byte at 7FFH", v, 8'hFF);
      pulse_step();
      read(4'b0011, v); check("R3 wrap to 000H", v, 8'h24);

      // R2 clear wins over step
      pulse_step();
      read(4'b0011, v); check("R3 step to 001H", v, 8'h7E);
      cnt_clr = 1'b1; cnt_step = 1'b1; @(negedge clk);
      cnt_clr = 1'b0; cnt_step = 1'b0; @(negedge clk);
      read(4'b0011, v); check("R2 clear beats step", v, 8'h24);

      // R4 busy length at 005H
      for (int k = 0; k < 5; k++) pulse_step();
      fire(4'b1110, 1'b1, 8'h96);
      n = 0;
      while (busy) begin n++; @(negedge clk); end
      check("R4 busy length", 8'(n), 8'(W));
      wait_idle();
      read(4'b0011, v); check("R11 code read", v, 8'h96);

      // R11 no hv, invalid mode
      fire(4'b1110, 1'b0, 8'h00); @(negedge clk);
      check("R11 no start without hv", {7'd0, busy}, 8'h00);
      fire(4'b0101, 1'b1, 8'h00); @(negedge clk);
      check("R11 no start on bad mode", {7'd0, busy}, 8'h00);
      hv_en = 1'b0;
      read(4'b0101, v); check("R11 bad mode reads FF", v, 8'hFF);
      read(4'b0011, v); check("R11 byte untouched", v, 8'h96);

      // R10 signatures
      pulse_clr();
      read(4'b0000, v); check("R10 sig 000H", v, 8'h1E);
      pulse_step(); read(4'b0000, v); check("R10 sig 001H", v, 8'h21);
      pulse_step(); read(4'b0000, v); check("R10 sig 002H", v, SG2);
      pulse_step(); read(4'b0000, v); check("R10 sig 003H", v, 8'hFF);

      // R8 locks
      pulse_step(); pulse_step();          // 005H
      fire(4'b1111, 1'b1, 8'h00); wait_idle();
      fire(4'b1110, 1'b1, 8'h00); @(negedge clk);
      check("R8 LB1 no busy", {7'd0, busy}, 8'h00);
      wait_idle();
      read(4'b0011, v); check("R8 LB1 blocks write", v, 8'h96);
      fire(4'b1011, 1'b1, 8'h00); wait_idle();
      read(4'b0011, v); check("R8 both locks blank read", v, 8'hFF);
      pulse_clr();
      read(4'b0000, v); check("R10 sig with locks", v, 8'h1E);

      // R9 erase
      fire(4'b1000, 1'b1, 8'h00); wait_idle();
      read(4'b0011, v); check("R9 erased 000H", v, 8'hFF);
      for (int k = 0; k < 5; k++) pulse_step();
      read(4'b0011, v); check("R9 erased 005H", v, 8'hFF);
      fire(4'b1110, 1'b1, 8'h5A); wait_idle();
      read(4'b0011, v); check("R9 locks cleared", v, 8'h5A);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule